// File: doc/BRIEF.md
# Legacy INTx Gate Controller

This block sits, one per function, between a device's internal interrupt request and its level-sensitive legacy INTx wire. The device raises a one-cycle assert request when it wants service and a one-cycle deassert request when the condition clears. The block drives the wire only while a request is outstanding and the function is allowed to use legacy interrupts. That permission can change at any moment through configuration writes.

A request that arrives while legacy interrupts are blocked is held and delivered on its own once they are unblocked. Blocking the interrupt while the wire is high pulls the wire low but keeps the request. Each rising and falling edge of the wire is also reported as a one-cycle event pulse, so that a downstream router which counts active sources can be fed directly.

Top module: `intx_gate`

## Requirements
- R1: After reset the wire is low, both event pulses are low and no request is held. Granting permission with no request leaves the wire low.
- R2: An assert request with no request outstanding and permission present drives the wire high at the next clock edge, with assertEvt high for that one cycle.
- R3: An assert request with no request outstanding and permission absent leaves the wire low and holds the request.
- R4: A deassert request while the wire is high drives it low at the next edge, with deassertEvt high for that one cycle, and clears the request.
- R5: A deassert request while a request is held but blocked clears it without any change on the wire. A later grant of permission does not raise the wire.
- R6: Withdrawing permission while the wire is high drives it low with a deassertEvt pulse and keeps the request, so that restoring permission raises the wire again.
- R7: Granting permission while a request is held raises the wire at the next edge with an assertEvt pulse.
- R8: Permission is present only when intxDisable is 0 and every bit of msgEnable is 0. Any single one of these inputs set blocks the wire.
- R9: An assert request while a request is already outstanding (wire high or held) is ignored. A deassert request with no request outstanding is ignored.
- R10: When a request and a permission change arrive in the same cycle, the request is applied first and the new permission level is then applied to the result.
- R11: assertEvt and deassertEvt each last exactly one cycle, occur only in the cycle the wire rises or falls respectively, and never occur together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| assertReq | input | 1 | One-cycle request to raise the interrupt |
| deassertReq | input | 1 | One-cycle request to withdraw the interrupt |
| intxDisable | input | 1 | Legacy interrupt disable from the command register |
| msgEnable | input | MSG_SRC (2) | Enable bits of message-signalled interrupt schemes |
| intxLine | output | 1 | Level INTx wire, active high |
| assertEvt | output | 1 | One-cycle pulse when intxLine rises |
| deassertEvt | output | 1 | One-cycle pulse when intxLine falls |

## Verification
A vector table walks the controller through requests under full permission, under each of the three blocking inputs taken alone, and with permission toggled while a request is high or held. These patterns separate a controller that drops a blocked request from one that holds it, and one that ignores repeated or stray requests from one that reacts to them. Same-cycle combinations of a request with a permission change tell apart request-first ordering from permission-first ordering. A reset applied while the wire is high confirms that no state survives it.

// File: rtl/intx_gate_pkg.sv
package intx_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ASSERTED = 2'd1,
    ST_PENDING  = 2'd2
  } gateState_t;

  // Strobes from control to line datapath.
  typedef struct packed {
    logic raise;
    logic drop;
  } lineCmd_t;

endpackage

// File: rtl/intx_gate_ctrl.sv
module intx_gate_ctrl
  import intx_gate_pkg::*;
#(
  parameter int MSG_SRC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               assertReq,
  input  logic               deassertReq,
  input  logic               intxDisable,
  input  logic [MSG_SRC-1:0] msgEnable,
  output lineCmd_t           lineCmd
);

  gateState_t stateQ, afterReq, stateD;
  logic permitted;

  // R8: permission needs legacy enable and no message scheme active
  assign permitted = ~intxDisable & ~(|msgEnable);

  // R10: apply the request first
  always_comb begin
    afterReq = stateQ;
    unique case (stateQ)
      ST_IDLE:     if (assertReq) afterReq = ST_PENDING;   // R9: deassert ignored here
      ST_ASSERTED: if (deassertReq) afterReq = ST_IDLE;    // R9: assert ignored here
      ST_PENDING:  if (deassertReq) afterReq = ST_IDLE;
      default:     afterReq = ST_IDLE;
    endcase
  end

  // then the permission level
  always_comb begin
    stateD = afterReq;
    if (afterReq == ST_PENDING && permitted) stateD = ST_ASSERTED;
    else if (afterReq == ST_ASSERTED && !permitted) stateD = ST_PENDING;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign lineCmd.raise = (stateD == ST_ASSERTED) && (stateQ != ST_ASSERTED);
  assign lineCmd.drop  = (stateQ == ST_ASSERTED) && (stateD != ST_ASSERTED);

  p_legal_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    stateQ inside {ST_IDLE, ST_ASSERTED, ST_PENDING});
  p_assert_perm_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && assertReq && permitted) |=> stateQ == ST_ASSERTED);
  p_assert_blocked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && assertReq && !permitted) |=> stateQ == ST_PENDING);
  p_deassert_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE && deassertReq) |=> stateQ == ST_IDLE);
  p_revoke_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ASSERTED && !deassertReq && !permitted) |=> stateQ == ST_PENDING);
  p_grant_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PENDING && !deassertReq && permitted) |=> stateQ == ST_ASSERTED);
  p_idle_stray_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !assertReq) |=> stateQ == ST_IDLE);

endmodule

// File: rtl/intx_gate_dp.sv
module intx_gate_dp
  import intx_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  lineCmd_t lineCmd,
  output logic     intxLine,
  output logic     assertEvt,
  output logic     deassertEvt
);

  logic lineQ, riseQ, fallQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ <= 1'b0;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      riseQ <= lineCmd.raise & ~lineQ;
      fallQ <= lineCmd.drop & lineQ;
      if (lineCmd.raise)     lineQ <= 1'b1;
      else if (lineCmd.drop) lineQ <= 1'b0;
    end
  end

  assign intxLine    = lineQ;
  assign assertEvt   = riseQ;
  assign deassertEvt = fallQ;

  p_cmd_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(lineCmd.raise && lineCmd.drop));
  p_rise_evt_r11: assert property (@(posedge clk) disable iff (!rstN)
    assertEvt |-> (lineQ && !$past(lineQ)));
  p_fall_evt_r11: assert property (@(posedge clk) disable iff (!rstN)
    deassertEvt |-> (!lineQ && $past(lineQ)));
  p_evt_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    assertEvt |=> !assertEvt);

endmodule

// File: rtl/intx_gate.sv
module intx_gate
  import intx_gate_pkg::*;
#(
  parameter int MSG_SRC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               assertReq,
  input  logic               deassertReq,
  input  logic               intxDisable,
  input  logic [MSG_SRC-1:0] msgEnable,
  output logic               intxLine,
  output logic               assertEvt,
  output logic               deassertEvt
);

  lineCmd_t lineCmd;

  intx_gate_ctrl #(.MSG_SRC(MSG_SRC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .assertReq(assertReq), .deassertReq(deassertReq),
    .intxDisable(intxDisable), .msgEnable(msgEnable),
    .lineCmd(lineCmd)
  );

  intx_gate_dp uDp (
    .clk(clk), .rstN(rstN), .lineCmd(lineCmd),
    .intxLine(intxLine), .assertEvt(assertEvt), .deassertEvt(deassertEvt)
  );

  p_line_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intxDisable || (|msgEnable)) |=> !intxLine);

endmodule

// File: tb/sim_intx_gate.sv
module sim_intx_gate;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic assertReq = 1'b0, deassertReq = 1'b0, intxDisable = 1'b0;
  logic [1:0] msgEnable = 2'b00;
  logic intxLine, assertEvt, deassertEvt;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  intx_gate #(.MSG_SRC(2)) u0 (
    .clk(clk), .rstN(rstN), .assertReq(assertReq), .deassertReq(deassertReq),
    .intxDisable(intxDisable), .msgEnable(msgEnable),
    .intxLine(intxLine), .assertEvt(assertEvt), .deassertEvt(deassertEvt)
  );

  // {assertReq, deassertReq, intxDisable, msgEnable[1:0], expLine, expRise, expFall}
  localparam int NVEC = 26;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b00_0_00_000, // R1 idle
    8'b00_0_00_000, // R1 grant with nothing held
    8'b10_0_00_110, // R2 assert with permission
    8'b00_0_00_100, // R11 pulse only one cycle
    8'b10_0_00_100, // R9 assert while high ignored
    8'b01_0_00_001, // R4 deassert
    8'b01_0_00_000, // R9 stray deassert
    8'b10_1_00_000, // R3 blocked assert
    8'b00_1_00_000, // R3 held, still low
    8'b10_1_00_000, // R9 assert while held ignored
    8'b00_0_00_110, // R7 grant raises
    8'b00_0_01_001, // R6 R8 msg bit 0 blocks
    8'b00_0_01_000, // R6 stays low
    8'b00_0_10_000, // R8 msg bit 1 blocks
    8'b00_0_00_110, // R6 request kept, restored
    8'b01_1_00_001, // R10 deassert and revoke together
    8'b00_0_00_000, // R10 nothing left
    8'b10_1_00_000, // R3 held again
    8'b01_0_00_000, // R10 R5 deassert and grant together
    8'b00_0_00_000, // R5 no raise
    8'b10_0_00_110, // R2 raise
    8'b10_1_00_001, // R10 assert ignored, revoke applies
    8'b01_1_00_000, // R5 deassert while held
    8'b00_0_00_000, // R5 grant does nothing
    8'b10_0_11_000, // R8 both msg bits block
    8'b01_0_00_000  // R5 clear it
  };

  task automatic check3(input string tag, input logic l, input logic r, input logic f);
    checks++;
    if ({intxLine, assertEvt, deassertEvt} !== {l, r, f}) begin
      failures++;
      $display("FAIL %s: got line/rise/fall=%b%b%b expected %b%b%b",
               tag, intxLine, assertEvt, deassertEvt, l, r, f);
    end
  endtask

  task automatic drive(input logic a, input logic d, input logic dis, input logic [1:0] m);
    assertReq = a; deassertReq = d; intxDisable = dis; msgEnable = m;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check3("R1 in reset", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check3("R1 after reset", 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4:3]);
      check3($sformatf("vector %0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R1: reset while high clears everything
    drive(1'b1, 1'b0, 1'b0, 2'b00);
    check3("R2 before reset", 1'b1, 1'b1, 1'b0);
    assertReq = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check3("R1 reset while high", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 2'b00);
    check3("R1 no request survives reset", 1'b0, 1'b0, 1'b0);

    // R8: intxDisable and a msg bit together, then release one at a time
    drive(1'b1, 1'b0, 1'b1, 2'b01);
    check3("R8 all blocking", 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 2'b01);
    check3("R8 msg still blocks", 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 2'b00);
    check3("R7 R8 released", 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 2'b00);
    check3("R4 final drop", 1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 2'b00);
    check3("R11 fall pulse one cycle", 1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule